// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs single-lane SPI flash transactions from a small register file. Software loads a 24-bit flash address and a 32-bit data word, then writes one command word. The engine drives SCK (idle high, SPI mode 3) and sends bytes in a fixed order: the opcode, then the address bytes, then dummy bytes, then up to four data bytes, which are either sent or received. Chip select can stay asserted after a command ends. A later command then continues the same flash transaction without resending the opcode and address. A command with nothing left to transfer simply releases the chip select.

SCK timing is set in core clock cycles: the bit period, the cycle in which SCK falls and the cycle in which it rises again. A status word shows whether a command is running and whether a command was refused. Two spare data lines can be held at fixed levels, so that the hold and write-protect pins of single-lane parts stay inactive.

Top module: `sflash_seq`

## Requirements
- R1: After reset, every chip select is high, SCK is high, MOSI is low, the spare lines are low, and the status, address and data registers read 0. The timing register reads 0x1304.
- R2: Registers are selected by word index: 0 command, 1 address, 2 data, 3 status, 4 timing, 5 spare-line control. The command word has these fields: opcode in bits 7:0, write flag in bit 8, data byte count in bits 11:9, keep-select in bit 15, dummy count in bits 19:16, address byte count in bits 22:20, and chip-select index in bits 26:24. Chip select index n drives cs_n_o[n] low.
- R3: Bytes go out in this order: opcode, address bytes with the most significant byte first, dummy bytes, data bytes. Each byte is sent MSB first. MOSI is 0 during dummy bytes and during read data.
- R4: Write data is taken little-endian from the data register, so bits 7:0 go out first.
- R5: In a read, MISO is sampled on each rising SCK edge. Received byte k is stored in data bits 8k+7:8k. Data bytes beyond the requested count keep their old value.
- R6: Timing register bits 3:0 set the bit period P in core cycles (values 0 and 1 act as 2). Bits 11:8 set R and bits 15:12 set F. Within each bit, SCK is low in cycles F to R-1 and high otherwise. A command with N bytes is busy for exactly 8*N*P cycles.
- R7: When keep-select is 1, chip select stays low after the command ends. When it is 0, chip select is released when the last bit completes.
- R8: A command issued while chip select is still held skips both the opcode and the address bytes.
- R9: A command with zero data bytes, zero dummy bytes and keep-select 0, issued while chip select is held, releases chip select in the next cycle. It generates no SCK edges and never shows pending.
- R10: Status bit 22 (pending) is 1 from the cycle after an accepted command until its last bit has finished.
- R11: A command written while pending is 1 is dropped and sets status bit 29 (error). Writing 1 to status bit 29 clears it, and writing 0 there leaves it unchanged.
- R12: A command with a data count above 4, an address count above 3 or a chip-select index of NUM_CS or more is rejected, and it sets the error flag.
- R13: Writes to the address, data and timing registers are ignored while pending is 1.
- R14: Bits 3:2 of the spare-line register drive spare_o[1:0] and read back in the same bit positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| sck_o | output | 1 | Serial clock, idle high |
| cs_n_o | output | NUM_CS | Chip selects, active low |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |
| spare_o | output | 2 | Levels for the two unused data lines |

## Verification
The cases below are chosen so that each one separates a particular kind of fault.

- **Opcode-only command.** Checks the basic SCK shape and that chip select is released at the end.
- **Full write (opcode, three address bytes, one dummy byte, four data bytes).** Separates byte-order faults in the address from byte-order faults in the data. A write to the address register made during this command must leave the shifted bits unchanged.
- **Three-byte read with a different period and edge placement.** Tests the timing fields and the sampling edge. Only the low three data bytes may change.
- **Period below the minimum.** Shows the clamp to 2 cycles.
- **Held chip-select chain (address-only command, then a continued read, then a bare release).** Separates header skipping from plain transfers.
- **Commands issued while busy, and malformed commands.** Tests error setting, clearing by writing 1, and that refused commands leave the bus idle.

// File: rtl/sflash_pkg.sv
`timescale 1ns/1ps
package sflash_pkg;

  localparam logic [2:0] REG_CMD  = 3'd0;
  localparam logic [2:0] REG_ADDR = 3'd1;
  localparam logic [2:0] REG_DATA = 3'd2;
  localparam logic [2:0] REG_STAT = 3'd3;
  localparam logic [2:0] REG_TIME = 3'd4;
  localparam logic [2:0] REG_IO   = 3'd5;

  localparam int STAT_PEND_BIT = 22;
  localparam int STAT_ERR_BIT  = 29;
  localparam logic [15:0] TIME_RESET = 16'h1304;

  typedef enum logic [2:0] {PH_OPC, PH_ADR, PH_DUM, PH_DAT, PH_END} phase_t;

  typedef struct packed {
    logic [2:0] cs;
    logic [2:0] alen;
    logic [3:0] dum;
    logic       keep;
    logic [2:0] dlen;
    logic       wr;
    logic [7:0] opc;
  } cmd_t;

  function automatic cmd_t cmd_decode(input logic [31:0] w);
    cmd_t c;
    c.opc  = w[7:0];
    c.wr   = w[8];
    c.dlen = w[11:9];
    c.keep = w[15];
    c.dum  = w[19:16];
    c.alen = w[22:20];
    c.cs   = w[26:24];
    return c;
  endfunction

  function automatic logic [3:0] ph_len(input phase_t p, input cmd_t c);
    case (p)
      PH_OPC:  return 4'd1;
      PH_ADR:  return {1'b0, c.alen};
      PH_DUM:  return c.dum;
      PH_DAT:  return {1'b0, c.dlen};
      default: return 4'd0;
    endcase
  endfunction

  function automatic phase_t ph_succ(input phase_t p);
    case (p)
      PH_OPC:  return PH_ADR;
      PH_ADR:  return PH_DUM;
      PH_DUM:  return PH_DAT;
      default: return PH_END;
    endcase
  endfunction

  // Advance past phases that carry no bytes for this command.
  function automatic phase_t ph_skip(input phase_t p, input cmd_t c);
    phase_t q;
    q = p;
    if (q == PH_ADR && c.alen == 3'd0) q = PH_DUM;
    if (q == PH_DUM && c.dum == 4'd0)  q = PH_DAT;
    if (q == PH_DAT && c.dlen == 3'd0) q = PH_END;
    return q;
  endfunction

  function automatic logic [7:0] ph_byte(input phase_t p, input logic [3:0] idx,
                                         input cmd_t c, input logic [23:0] addr,
                                         input logic [31:0] wdata);
    logic [23:0] a;
    logic [31:0] d;
    case (p)
      PH_OPC: return c.opc;
      PH_ADR: begin
        a = addr >> (8 * (int'(c.alen) - 1 - int'(idx)));
        return a[7:0];
      end
      PH_DAT: begin
        d = wdata >> (8 * int'(idx));
        return c.wr ? d[7:0] : 8'h00;
      end
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [3:0] sck_period(input logic [3:0] per);
    return (per < 4'd2) ? 4'd2 : per;
  endfunction

endpackage

// File: rtl/sflash_sckgen.sv
`timescale 1ns/1ps
module sflash_sckgen
  import sflash_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] fall_i,
  input  logic [CNT_W-1:0] rise_i,
  output logic             sck_o,
  output logic             sample_o,
  output logic             bit_end_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;

  assign last_cnt  = sck_period(per_i) - 4'd1;
  assign bit_end_o = run_i && (cnt_q == last_cnt);
  assign sample_o  = run_i && (rise_i != '0) && (cnt_q == rise_i - 4'd1);
  assign sck_o     = !(run_i && (cnt_q >= fall_i) && (cnt_q < rise_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!run_i || bit_end_o) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 4'd1;
  end
endmodule

// File: rtl/sflash_engine.sv
`timescale 1ns/1ps
module sflash_engine
  import sflash_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        skip_hdr_i,
  input  cmd_t        cmd_i,
  input  logic [23:0] addr_i,
  input  logic [31:0] wdata_i,
  input  logic        sample_i,
  input  logic        bit_end_i,
  input  logic        miso_i,
  output logic        busy_o,
  output logic        mosi_o,
  output logic        done_o,
  output logic        rx_we_o,
  output logic [1:0]  rx_idx_o,
  output logic [7:0]  rx_byte_o
);
  phase_t     ph_q, start_ph, next_ph;
  logic [3:0] idx_q, next_idx;
  logic [2:0] bit_q;
  logic [7:0] tx_q, rx_q;
  cmd_t       cmd_q;
  logic       busy_q, byte_end, last_byte;

  always_comb begin
    start_ph  = skip_hdr_i ? ph_skip(PH_DUM, cmd_i) : PH_OPC;
    byte_end  = busy_q && bit_end_i && (bit_q == 3'd7);
    last_byte = (idx_q + 4'd1) == ph_len(ph_q, cmd_q);
    next_ph   = last_byte ? ph_skip(ph_succ(ph_q), cmd_q) : ph_q;
    next_idx  = last_byte ? 4'd0 : idx_q + 4'd1;
  end

  assign done_o    = byte_end && (next_ph == PH_END);
  assign rx_we_o   = byte_end && (ph_q == PH_DAT) && !cmd_q.wr;
  assign rx_idx_o  = idx_q[1:0];
  assign rx_byte_o = rx_q;
  assign busy_o    = busy_q;
  assign mosi_o    = busy_q && tx_q[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= PH_END;
      idx_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      cmd_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      ph_q   <= start_ph;
      idx_q  <= '0;
      bit_q  <= '0;
      cmd_q  <= cmd_i;
      tx_q   <= ph_byte(start_ph, 4'd0, cmd_i, addr_i, wdata_i);
    end else if (busy_q) begin
      if (sample_i) rx_q <= {rx_q[6:0], miso_i};
      if (bit_end_i) begin
        if (bit_q == 3'd7) begin
          bit_q <= '0;
          if (done_o) begin
            busy_q <= 1'b0;
            ph_q   <= PH_END;
          end else begin
            ph_q  <= next_ph;
            idx_q <= next_idx;
            tx_q  <= ph_byte(next_ph, next_idx, cmd_q, addr_i, wdata_i);
          end
        end else begin
          bit_q <= bit_q + 3'd1;
          tx_q  <= {tx_q[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/sflash_seq.sv
`timescale 1ns/1ps
module sflash_seq
  import sflash_pkg::*;
#(
  parameter int NUM_CS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sck_o,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [1:0]        spare_o
);
  localparam logic [3:0] CS_LIMIT = 4'(NUM_CS);

  logic [23:0] addr_q;
  logic [31:0] data_q;
  logic [15:0] tim_q;
  logic [1:0]  io_q;
  logic        err_q, cs_act_q, keep_q;
  logic [2:0]  cs_idx_q;

  cmd_t        cmd_w;
  logic        cmd_wr, cmd_bad, cmd_ok, held, nothing_left, rel_only;
  logic        eng_start, eng_busy, eng_done, rx_we, sample, bit_end, cfg_wr_ok;
  logic [1:0]  rx_idx;
  logic [7:0]  rx_byte;

  assign cmd_w        = cmd_decode(bus_wdata);
  assign cmd_wr       = bus_we && (bus_addr == REG_CMD);
  assign cmd_bad      = (cmd_w.dlen > 3'd4) || (cmd_w.alen > 3'd3) || ({1'b0, cmd_w.cs} >= CS_LIMIT);
  assign cmd_ok       = cmd_wr && !eng_busy && !cmd_bad;
  assign held         = cs_act_q && !eng_busy;
  assign nothing_left = held && (cmd_w.dum == 4'd0) && (cmd_w.dlen == 3'd0);
  assign eng_start    = cmd_ok && !nothing_left;
  assign rel_only     = cmd_ok && nothing_left;
  assign cfg_wr_ok    = bus_we && !eng_busy;

  sflash_sckgen #(.CNT_W(4)) sck_i (
    .clk(clk), .rst_n(rst_n), .run_i(eng_busy),
    .per_i(tim_q[3:0]), .fall_i(tim_q[15:12]), .rise_i(tim_q[11:8]),
    .sck_o(sck_o), .sample_o(sample), .bit_end_o(bit_end)
  );

  sflash_engine eng_i (
    .clk(clk), .rst_n(rst_n), .start_i(eng_start), .skip_hdr_i(held),
    .cmd_i(cmd_w), .addr_i(addr_q), .wdata_i(data_q),
    .sample_i(sample), .bit_end_i(bit_end), .miso_i(miso_i),
    .busy_o(eng_busy), .mosi_o(mosi_o), .done_o(eng_done),
    .rx_we_o(rx_we), .rx_idx_o(rx_idx), .rx_byte_o(rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      tim_q  <= TIME_RESET;
      io_q   <= '0;
    end else begin
      if (cfg_wr_ok && bus_addr == REG_ADDR) addr_q <= bus_wdata[23:0];
      if (cfg_wr_ok && bus_addr == REG_TIME) tim_q  <= bus_wdata[15:0];
      if (bus_we && bus_addr == REG_IO)      io_q   <= bus_wdata[3:2];
      if (rx_we)                             data_q[{rx_idx, 3'b000} +: 8] <= rx_byte;
      else if (cfg_wr_ok && bus_addr == REG_DATA) data_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else if (cmd_wr && (eng_busy || cmd_bad)) err_q <= 1'b1;
    else if (bus_we && bus_addr == REG_STAT && bus_wdata[STAT_ERR_BIT]) err_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_act_q <= 1'b0;
      cs_idx_q <= '0;
      keep_q   <= 1'b0;
    end else if (eng_start) begin
      cs_act_q <= 1'b1;
      cs_idx_q <= cmd_w.cs;
      keep_q   <= cmd_w.keep;
    end else if (rel_only) begin
      cs_act_q <= cmd_w.keep;
    end else if (eng_done) begin
      cs_act_q <= keep_q;
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n_o[i] = !(cs_act_q && (cs_idx_q == 3'(i)));
  end

  assign spare_o = io_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_ADDR: bus_rdata = {8'd0, addr_q};
      REG_DATA: bus_rdata = data_q;
      REG_STAT: begin
        bus_rdata[STAT_PEND_BIT] = eng_busy;
        bus_rdata[STAT_ERR_BIT]  = err_q;
      end
      REG_TIME: bus_rdata = {16'd0, tim_q};
      REG_IO:   bus_rdata = {28'd0, io_q, 2'b00};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sflash_seq_chk.sv
`timescale 1ns/1ps
module sflash_seq_chk
  import sflash_pkg::*;
#(
  parameter int NUM_CS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [2:0]        bus_addr,
  input logic              cmd_wr,
  input logic              cmd_bad,
  input logic              eng_start,
  input logic              eng_busy,
  input logic              err_q,
  input logic [23:0]       addr_q,
  input logic              sck_o,
  input logic [NUM_CS-1:0] cs_n_o
);
  // R2: at most one chip select low
  p_one_cs_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n_o));
  // R6: SCK idles high whenever no command runs
  p_sck_idle_r6: assert property (@(posedge clk) disable iff (!rst_n) !eng_busy |-> sck_o);
  // R10: a running command always has its chip select low
  p_busy_cs_r10: assert property (@(posedge clk) disable iff (!rst_n) eng_busy |-> !(&cs_n_o));
  // R10: an accepted command shows pending next cycle
  p_start_pend_r10: assert property (@(posedge clk) disable iff (!rst_n) eng_start |=> eng_busy);
  // R11: a command during pending raises the error flag
  p_busy_err_r11: assert property (@(posedge clk) disable iff (!rst_n) (cmd_wr && eng_busy) |=> err_q);
  // R12: a malformed command starts nothing and moves no chip select
  p_reject_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !eng_busy && cmd_bad) |=> (!eng_busy && $stable(cs_n_o) && err_q));
  // R13: address register frozen while pending
  p_addr_frozen_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == REG_ADDR && eng_busy) |=> $stable(addr_q));
endmodule

bind sflash_seq sflash_seq_chk #(.NUM_CS(NUM_CS)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .cmd_wr(cmd_wr), .cmd_bad(cmd_bad), .eng_start(eng_start), .eng_busy(eng_busy),
  .err_q(err_q), .addr_q(addr_q), .sck_o(sck_o), .cs_n_o(cs_n_o)
);

// File: tb/sflash_seq_tb.sv
`timescale 1ns/1ps
module sflash_seq_tb_top;
  localparam int NCS = 2;
  localparam logic [2:0] A_CMD = 3'd0, A_ADDR = 3'd1, A_DATA = 3'd2,
                         A_STAT = 3'd3, A_TIME = 3'd4, A_IO = 3'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic sck_o, mosi_o, miso_i;
  logic [NCS-1:0] cs_n_o;
  logic [1:0] spare_o;

  int checks = 0;
  int errors = 0;
  bit exp_q[$];
  bit miso_q[$];
  logic sck_prev = 1'b1;

  always #10 clk = ~clk;

  sflash_seq #(.NUM_CS(NCS)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_o(sck_o),
    .cs_n_o(cs_n_o), .mosi_o(mosi_o), .miso_i(miso_i), .spare_o(spare_o)
  );

  // Flash model: presents the next queued bit after every falling SCK edge.
  initial miso_i = 1'b0;
  always @(negedge clk) begin
    if (sck_prev && !sck_o) miso_i <= (miso_q.size() > 0) ? miso_q.pop_front() : 1'b0;
    sck_prev <= sck_o;
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cmd(input logic [7:0] opc, input bit wr, input int dlen,
                                         input bit keep, input int dum, input int alen, input int cs);
    return 32'(opc) | (32'(wr) << 8) | (32'(dlen) << 9) | (32'(keep) << 15)
         | (32'(dum) << 16) | (32'(alen) << 20) | (32'(cs) << 24);
  endfunction

  task automatic push_tx(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) exp_q.push_back(b[i]);
  endtask

  task automatic push_rx(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) miso_q.push_back(b[i]);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // Cycle-by-cycle model of one command; called at the first negedge after the command write.
  task automatic run_expect(input string req, input int per, input int fall, input int rise,
                            input int csx, input bit keep_after, input int inj_k,
                            input logic [2:0] inj_a, input logic [31:0] inj_d);
    int p, total, bad;
    logic [31:0] act_v, exp_v, st;
    logic [NCS-1:0] cs_sel;
    p = (per < 2) ? 2 : per;
    total = exp_q.size() * p;
    bad = 0; act_v = '0; exp_v = '0;
    cs_sel = ~(NCS'(1) << csx);
    for (int k = 0; k < total; k++) begin
      logic e_sck, e_mosi;
      int c;
      c = k % p;
      e_sck = !(c >= fall && c < rise);
      e_mosi = exp_q[k / p];
      if (k == inj_k) begin
        bus_we = 1'b1; bus_addr = inj_a; bus_wdata = inj_d;
        st = 32'h0040_0000;
      end else begin
        bus_we = 1'b0;
        rd(A_STAT, st);
      end
      if (bad == 0 && ({sck_o, mosi_o, cs_n_o, st[22]} !== {e_sck, e_mosi, cs_sel, 1'b1})) begin
        bad = k + 1;
        act_v = 32'({sck_o, mosi_o, cs_n_o, st[22]});
        exp_v = 32'({e_sck, e_mosi, cs_sel, 1'b1});
      end
      @(negedge clk);
    end
    bus_we = 1'b0;
    check(req, $sformatf("wave {sck,mosi,cs_n,pend} first bad cycle %0d", bad - 1), act_v, exp_v);
    rd(A_STAT, st);
    check(req, "pending cleared at end", 32'(st[22]), 32'd0);
    check(req, "sck idle", 32'(sck_o), 32'd1);
    check("R7", "chip select after command", 32'(cs_n_o), 32'(keep_after ? cs_sel : {NCS{1'b1}}));
    exp_q.delete();
    miso_q.delete();
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(A_STAT, v); check("R1", "status", v, 32'd0);
    rd(A_TIME, v); check("R1", "timing", v, 32'h1304);
    rd(A_ADDR, v); check("R1", "addr", v, 32'd0);
    rd(A_DATA, v); check("R1", "data", v, 32'd0);
    check("R1", "cs_n", 32'(cs_n_o), 32'(2'b11));
    check("R1", "sck/mosi/spare", 32'({sck_o, mosi_o, spare_o}), 32'(4'b1000));
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R6: opcode only, release at end
    push_tx(8'h06);
    wr(A_CMD, mk_cmd(8'h06, 0, 0, 0, 0, 0, 0));
    run_expect("R2", 4, 1, 3, 0, 0, -1, 3'd0, 32'd0);

    // R3 R4 R10 R13: full write, address write during pending
    wr(A_ADDR, 32'h0012_3456);
    wr(A_DATA, 32'hDDCC_BBAA);
    push_tx(8'h02); push_tx(8'h12); push_tx(8'h34); push_tx(8'h56); push_tx(8'h00);
    push_tx(8'hAA); push_tx(8'hBB); push_tx(8'hCC); push_tx(8'hDD);
    wr(A_CMD, mk_cmd(8'h02, 1, 4, 0, 1, 3, 0));
    run_expect("R3", 4, 1, 3, 0, 0, 10, A_ADDR, 32'h00FF_FFFF);
    rd(A_ADDR, v); check("R13", "addr write during pending ignored", v, 32'h0012_3456);
    rd(A_DATA, v); check("R4", "write leaves data register", v, 32'hDDCC_BBAA);

    // R5 R6: three-byte read, P=6 F=2 R=5
    wr(A_TIME, 32'h0000_2506);
    wr(A_DATA, 32'h7766_5544);
    wr(A_ADDR, 32'h0000_ABCD);
    push_tx(8'h0B); push_tx(8'h00); push_tx(8'hAB); push_tx(8'hCD); push_tx(8'h00);
    push_tx(8'h00); push_tx(8'h00); push_tx(8'h00);
    for (int i = 0; i < 5; i++) push_rx(8'h00);
    push_rx(8'h3C); push_rx(8'hA5); push_rx(8'h81);
    wr(A_CMD, mk_cmd(8'h0B, 0, 3, 0, 1, 3, 0));
    run_expect("R6", 6, 2, 5, 0, 0, -1, 3'd0, 32'd0);
    rd(A_DATA, v); check("R5", "read bytes little-endian, top byte kept", v, 32'h7781_A53C);

    // R6: period below minimum acts as 2
    wr(A_TIME, 32'h0000_0101);
    push_tx(8'h9F);
    wr(A_CMD, mk_cmd(8'h9F, 0, 0, 0, 0, 0, 0));
    run_expect("R6", 2, 0, 1, 0, 0, -1, 3'd0, 32'd0);
    wr(A_TIME, 32'h0000_1304);
    rd(A_TIME, v); check("R2", "timing readback", v, 32'h1304);

    // R7 R8 R9: held chain
    wr(A_ADDR, 32'h0000_0010);
    push_tx(8'h03); push_tx(8'h00); push_tx(8'h00); push_tx(8'h10);
    wr(A_CMD, mk_cmd(8'h03, 0, 0, 1, 0, 3, 0));
    run_expect("R7", 4, 1, 3, 0, 1, -1, 3'd0, 32'd0);
    push_tx(8'h00); push_tx(8'h00);
    push_rx(8'h5A); push_rx(8'hC3);
    wr(A_CMD, mk_cmd(8'hFF, 0, 2, 1, 0, 3, 0));
    run_expect("R8", 4, 1, 3, 0, 1, -1, 3'd0, 32'd0);
    rd(A_DATA, v); check("R8", "continued read data", v, 32'h7781_C35A);
    wr(A_CMD, mk_cmd(8'h00, 0, 0, 0, 0, 0, 0));
    check("R9", "release-only frees chip select", 32'(cs_n_o), 32'(2'b11));
    rd(A_STAT, v); check("R9", "release-only no pending", v, 32'd0);
    for (int i = 0; i < 4; i++) begin
      check("R9", "no sck edge", 32'(sck_o), 32'd1);
      @(negedge clk);
    end

    // R11: command during pending on chip select 1
    push_tx(8'h05);
    wr(A_CMD, mk_cmd(8'h05, 0, 0, 0, 0, 0, 1));
    run_expect("R11", 4, 1, 3, 1, 0, 3, A_CMD, mk_cmd(8'h9F, 0, 0, 0, 0, 0, 0));
    rd(A_STAT, v); check("R11", "error set", v, 32'h2000_0000);
    wr(A_STAT, 32'h0000_0000);
    rd(A_STAT, v); check("R11", "write 0 keeps error", v, 32'h2000_0000);
    wr(A_STAT, 32'h2000_0000);
    rd(A_STAT, v); check("R11", "write 1 clears error", v, 32'd0);

    // R12: malformed commands
    wr(A_CMD, mk_cmd(8'h06, 0, 5, 0, 0, 0, 0));
    rd(A_STAT, v); check("R12", "dlen 5 rejected", v, 32'h2000_0000);
    check("R12", "dlen 5 no chip select", 32'({cs_n_o, sck_o}), 32'(3'b111));
    wr(A_STAT, 32'h2000_0000);
    wr(A_CMD, mk_cmd(8'h06, 0, 0, 0, 0, 0, 2));
    rd(A_STAT, v); check("R12", "cs index 2 rejected", v, 32'h2000_0000);
    check("R12", "cs index 2 no chip select", 32'(cs_n_o), 32'(2'b11));
    wr(A_STAT, 32'h2000_0000);
    wr(A_CMD, mk_cmd(8'h06, 0, 0, 0, 0, 4, 0));
    rd(A_STAT, v); check("R12", "alen 4 rejected", v, 32'h2000_0000);
    wr(A_STAT, 32'h2000_0000);

    // R14: spare lines
    wr(A_IO, 32'h0000_000C);
    check("R14", "spare lines high", 32'(spare_o), 32'(2'b11));
    rd(A_IO, v); check("R14", "spare readback", v, 32'h0000_000C);
    wr(A_IO, 32'h0000_0004);
    check("R14", "spare line 0 only", 32'(spare_o), 32'(2'b01));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule